// File: doc/BRIEF.md
# Link Status Register with Training Tracking

This block holds the 16-bit status word of a serial link port. The word is assembled from registered state that the block keeps itself. Three inputs feed it: the physical layer's training state machine, the data link layer, and the Retrain Link command strobe that the neighbouring control register raises. Software reads the word continuously on `rdata` and writes it through a single write strobe with data.

Most fields are plain snapshots of incoming state:
- the data-link-active flag;
- the fixed slot clock choice;
- the lane width captured when the link enters its normal operating state.

Two fields follow their own rules:
- The training bit covers the gap between a retrain command and the moment training actually starts.
- The bandwidth-change flag is sticky. Hardware sets it on completed commanded retrains and on unrequested speed or width changes. Software clears it by writing one to it.

Top module: `link_status_reg`

## Requirements
- R1: After synchronous reset the word reads 16'h1000: bit 12 holds the slot clock parameter (default 1) and every other bit is 0.
- R2: Bit 10 (training) reads 1 in the cycle after `cfg_rec` is high. It also reads 1 from the cycle after a `retrain_cmd` pulse until the cycle after `cfg_rec` is first seen high. It reads 0 once `cfg_rec` is low and no command is pending.
- R3: Bit 14 is set one cycle after a commanded retrain completes. A retrain completes when `cfg_rec` falls after having been seen high following the last `retrain_cmd`. If `dl_down` is seen between the command and the completion, the retrain is abandoned and bit 14 is not set by it. A command that arrives while the link is already retraining restarts this tracking.
- R4: Bit 14 is set one cycle after a pulse on `auto_bw_chg` (an autonomous speed or width change) or on `peer_bw_chg` (a change started by the link partner that was not flagged as autonomous).
- R5: Bit 14 is sticky. It clears only on a write with `reg_wdata[14]`=1. A write with `reg_wdata[14]`=0 leaves it unchanged.
- R6: When a set event and a clearing write hit bit 14 in the same cycle, bit 14 reads 1 afterwards.
- R7: Bit 13 equals `dl_active` delayed by one cycle when `DLLA_CAP`=1, and reads 0 when `DLLA_CAP`=0.
- R8: Bit 12 always equals `SLOT_CLK_COMMON` (1 = platform reference clock from the connector, 0 = independent clock). Writes do not change it.
- R9: Bits 9:4 load `phy_width` in the cycle after `in_l0` rises (width codes 01h, 02h, 04h, 08h, 10h for one to sixteen lanes). They hold at all other times, including while `in_l0` stays high.
- R10: Bits 15, 11 and 3:0 read 0. Writes to any bit other than 14 have no effect on the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| rdata | output | 16 | Status word |
| retrain_cmd | input | 1 | One-cycle pulse: Retrain Link written with 1 |
| cfg_rec | input | 1 | Training state machine in Configuration or Recovery |
| in_l0 | input | 1 | Link in its normal operating state |
| phy_width | input | 6 | Negotiated width code from the physical layer |
| auto_bw_chg | input | 1 | Pulse: autonomous speed or width change for reliability |
| peer_bw_chg | input | 1 | Pulse: partner-initiated, non-autonomous change |
| dl_active | input | 1 | Data link layer in its active state |
| dl_down | input | 1 | Data link layer reports link down |

## Verification
Bit 14 can receive a hardware set event and a software clearing write in the same cycle. The set event may come from a retrain completion, an autonomous change or a partner change. The bench provokes this collision directly with each kind of set source paired with a write of bit 14, and it also produces it at random among thousands of mixed cycles. The result is judged against a bench model in which the set wins. Retrain commands that land during an ongoing training, and link-down events that land between a command and its completion, are also forced so that the completion rule is checked at its edges.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
  localparam int unsigned WORD_W   = 16;
  localparam int unsigned WIDTH_W  = 6;
  localparam int unsigned BIT_BW   = 14;
  localparam int unsigned BIT_DLA  = 13;
  localparam int unsigned BIT_SLOT = 12;
  localparam int unsigned BIT_TRN  = 10;
  localparam int unsigned WID_LSB  = 4;

  typedef enum logic [1:0] {
    TRK_IDLE = 2'd0,
    TRK_WAIT = 2'd1,
    TRK_BUSY = 2'd2
  } trk_e;
endpackage

// File: rtl/lsr_train_trk.sv
module lsr_train_trk
  import lsr_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic retrain_cmd,
  input  logic cfg_rec,
  input  logic dl_down,
  output logic train_o,
  output logic done_o
);
  logic pend_q, pend_n;
  logic train_q;
  trk_e st_q, st_n;

  // a command stays pending until the state machine is seen in training
  assign pend_n = retrain_cmd | (pend_q & ~cfg_rec);

  always_comb begin
    st_n = st_q;
    if (retrain_cmd) begin
      st_n = TRK_WAIT;
    end else if (dl_down) begin
      st_n = TRK_IDLE;
    end else begin
      case (st_q)
        TRK_WAIT: if (cfg_rec)  st_n = TRK_BUSY;
        TRK_BUSY: if (!cfg_rec) st_n = TRK_IDLE;
        default:  st_n = TRK_IDLE;
      endcase
    end
  end

  assign done_o = (st_q == TRK_BUSY) & ~cfg_rec & ~dl_down;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= 1'b0;
      train_q <= 1'b0;
      st_q    <= TRK_IDLE;
    end else begin
      pend_q  <= pend_n;
      train_q <= cfg_rec | pend_n;
      st_q    <= st_n;
    end
  end

  assign train_o = train_q;

  a_r2_cfg_sets_train: assert property (@(posedge clk) disable iff (rst)
    cfg_rec |=> train_o);
  a_r2_cmd_sets_train: assert property (@(posedge clk) disable iff (rst)
    retrain_cmd |=> train_o);
  a_r3_abort_on_down: assert property (@(posedge clk) disable iff (rst)
    (dl_down && !retrain_cmd) |=> (st_q == TRK_IDLE));
endmodule

// File: rtl/lsr_bw_flag.sv
module lsr_bw_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk) begin
    if (rst)        flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  a_r4_set_takes: assert property (@(posedge clk) disable iff (rst)
    set_i |=> flag_o);
  a_r5_sticky: assert property (@(posedge clk) disable iff (rst)
    (!set_i && !clr_i) |=> $stable(flag_o));
  a_r6_set_beats_clear: assert property (@(posedge clk) disable iff (rst)
    (set_i && clr_i) |=> flag_o);
endmodule

// File: rtl/lsr_width_cap.sv
module lsr_width_cap #(
  parameter int unsigned W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_l0,
  input  logic [W-1:0] width_i,
  output logic [W-1:0] width_o
);
  logic         l0_q;
  logic [W-1:0] width_q;
  logic         entry;

  assign entry = in_l0 & ~l0_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      l0_q    <= 1'b0;
      width_q <= '0;
    end else begin
      l0_q <= in_l0;
      if (entry) width_q <= width_i;
    end
  end

  assign width_o = width_q;

  a_r9_hold_off_entry: assert property (@(posedge clk) disable iff (rst)
    !(in_l0 && !l0_q) |=> $stable(width_o));
  a_r9_load_on_entry: assert property (@(posedge clk) disable iff (rst)
    (in_l0 && !l0_q) |=> (width_o == $past(width_i)));
endmodule

// File: rtl/link_status_reg.sv
module link_status_reg
  import lsr_pkg::*;
#(
  parameter bit DLLA_CAP        = 1'b1,
  parameter bit SLOT_CLK_COMMON = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] rdata,
  input  logic              retrain_cmd,
  input  logic              cfg_rec,
  input  logic              in_l0,
  input  logic [WIDTH_W-1:0] phy_width,
  input  logic              auto_bw_chg,
  input  logic              peer_bw_chg,
  input  logic              dl_active,
  input  logic              dl_down
);
  logic               train, done, bw_flag, dla;
  logic [WIDTH_W-1:0] width;
  logic               unused_inputs;

  assign unused_inputs = ^{reg_wdata[WORD_W-1:BIT_BW+1], reg_wdata[BIT_BW-1:0], dl_active};

  lsr_train_trk u_trk (
    .clk         (clk),
    .rst         (rst),
    .retrain_cmd (retrain_cmd),
    .cfg_rec     (cfg_rec),
    .dl_down     (dl_down),
    .train_o     (train),
    .done_o      (done)
  );

  lsr_bw_flag u_bw (
    .clk    (clk),
    .rst    (rst),
    .set_i  (done | auto_bw_chg | peer_bw_chg),
    .clr_i  (reg_wr & reg_wdata[BIT_BW]),
    .flag_o (bw_flag)
  );

  lsr_width_cap #(.W(WIDTH_W)) u_wid (
    .clk     (clk),
    .rst     (rst),
    .in_l0   (in_l0),
    .width_i (phy_width),
    .width_o (width)
  );

  generate
    if (DLLA_CAP) begin : g_dla
      logic dla_q;
      always_ff @(posedge clk) begin
        if (rst) dla_q <= 1'b0;
        else     dla_q <= dl_active;
      end
      assign dla = dla_q;
    end else begin : g_no_dla
      assign dla = 1'b0;
    end
  endgenerate

  always_comb begin
    rdata                              = '0;
    rdata[BIT_BW]                      = bw_flag;
    rdata[BIT_DLA]                     = dla;
    rdata[BIT_SLOT]                    = SLOT_CLK_COMMON;
    rdata[BIT_TRN]                     = train;
    rdata[WID_LSB +: WIDTH_W]          = width;
  end

  a_r7_dla_follows: assert property (@(posedge clk) disable iff (rst)
    dl_active |=> (rdata[BIT_DLA] == DLLA_CAP));
  a_r3_done_sets_flag: assert property (@(posedge clk) disable iff (rst)
    done |=> rdata[BIT_BW]);
  a_r4_peer_sets_flag: assert property (@(posedge clk) disable iff (rst)
    (auto_bw_chg || peer_bw_chg) |=> rdata[BIT_BW]);
endmodule

// File: tb/test_link_status_reg.sv
module test_link_status_reg;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] rdata;
  logic        retrain_cmd = 1'b0, cfg_rec = 1'b0, in_l0 = 1'b0;
  logic [5:0]  phy_width = '0;
  logic        auto_bw_chg = 1'b0, peer_bw_chg = 1'b0;
  logic        dl_active = 1'b0, dl_down = 1'b0;

  int vectors = 0;
  int fails   = 0;

  // bench model state
  bit       m_pend, m_train, m_bw, m_dla, m_l0q;
  int       m_st;
  bit [5:0] m_w;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_status_reg i_link_status_reg (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .rdata(rdata),
    .retrain_cmd(retrain_cmd), .cfg_rec(cfg_rec), .in_l0(in_l0), .phy_width(phy_width),
    .auto_bw_chg(auto_bw_chg), .peer_bw_chg(peer_bw_chg),
    .dl_active(dl_active), .dl_down(dl_down)
  );

  function automatic logic [15:0] expect_word();
    logic [15:0] e = '0;
    e[14]  = m_bw;
    e[13]  = m_dla;
    e[12]  = 1'b1;
    e[10]  = m_train;
    e[9:4] = m_w;
    return e;
  endfunction

  task automatic model_reset();
    m_pend = 0; m_train = 0; m_bw = 0; m_dla = 0; m_l0q = 0; m_st = 0; m_w = '0;
  endtask

  task automatic model_step();
    bit done, nx_pend;
    done    = (m_st == 2) && !cfg_rec && !dl_down;
    nx_pend = retrain_cmd || (m_pend && !cfg_rec);
    m_train = cfg_rec || nx_pend;
    m_pend  = nx_pend;
    if (retrain_cmd)  m_st = 1;
    else if (dl_down) m_st = 0;
    else if (m_st == 1) m_st = cfg_rec ? 2 : 1;
    else if (m_st == 2) m_st = cfg_rec ? 2 : 0;
    if (done || auto_bw_chg || peer_bw_chg) m_bw = 1;
    else if (reg_wr && reg_wdata[14])       m_bw = 0;
    if (in_l0 && !m_l0q) m_w = phy_width;
    m_l0q = in_l0;
    m_dla = dl_active;
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    logic [15:0] e;
    e = expect_word();
    chk("R5 bit14",   {15'd0, rdata[14]}, {15'd0, e[14]});
    chk("R2 bit10",   {15'd0, rdata[10]}, {15'd0, e[10]});
    chk("R7 bit13",   {15'd0, rdata[13]}, {15'd0, e[13]});
    chk("R8 bit12",   {15'd0, rdata[12]}, 16'd1);
    chk("R9 width",   {10'd0, rdata[9:4]}, {10'd0, e[9:4]});
    chk("R10 zeros",  {12'd0, rdata[15], rdata[11], rdata[3:2]}, 16'd0);
    chk("R10 zeros",  {14'd0, rdata[1:0]}, 16'd0);
  endtask

  // one clock: inputs already set, model follows the edge, then compare
  task automatic tick();
    @(posedge clk);
    if (rst) model_reset(); else model_step();
    #1;
    check_all();
    retrain_cmd = 0; auto_bw_chg = 0; peer_bw_chg = 0; dl_down = 0;
    reg_wr = 0; reg_wdata = '0;
  endtask

  task automatic clear_bw();
    reg_wr = 1; reg_wdata = 16'h4000; tick();
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    rst = 1; tick(); tick();
    chk("R1 reset word", rdata, 16'h1000);
    rst = 0; tick();

    // R2: command pends until training seen, then drops after exit
    retrain_cmd = 1; tick();
    chk("R2 pending", {15'd0, rdata[10]}, 16'd1);
    tick(); tick();
    chk("R2 still pending", {15'd0, rdata[10]}, 16'd1);
    cfg_rec = 1; tick(); tick();
    cfg_rec = 0; tick();
    chk("R3 completion sets", {15'd0, rdata[14]}, 16'd1);
    chk("R2 cleared", {15'd0, rdata[10]}, 16'd0);

    // R5: write of 0 keeps, write of 1 clears
    reg_wr = 1; reg_wdata = 16'hBFFF; tick();
    chk("R5 zero write keeps", {15'd0, rdata[14]}, 16'd1);
    chk("R10 other writes ignored", rdata & 16'hBFFF, 16'h1000 | {6'd0, m_w, 4'd0});
    clear_bw();
    chk("R5 cleared", {15'd0, rdata[14]}, 16'd0);

    // R3: command while already retraining, then completion
    cfg_rec = 1; tick(); tick();
    retrain_cmd = 1; tick(); tick();
    cfg_rec = 0; tick();
    chk("R3 retrain during training", {15'd0, rdata[14]}, 16'd1);
    clear_bw();

    // R3: link down between command and completion abandons it
    retrain_cmd = 1; tick();
    cfg_rec = 1; tick();
    dl_down = 1; tick();
    cfg_rec = 0; tick(); tick();
    chk("R3 abort on link down", {15'd0, rdata[14]}, 16'd0);

    // R6: each set source against a clearing write
    auto_bw_chg = 1; reg_wr = 1; reg_wdata = 16'h4000; tick();
    chk("R6 auto vs clear", {15'd0, rdata[14]}, 16'd1);
    peer_bw_chg = 1; reg_wr = 1; reg_wdata = 16'h4000; tick();
    chk("R6 peer vs clear", {15'd0, rdata[14]}, 16'd1);
    clear_bw();
    retrain_cmd = 1; tick(); cfg_rec = 1; tick();
    cfg_rec = 0; reg_wr = 1; reg_wdata = 16'h4000; tick();
    chk("R6 completion vs clear", {15'd0, rdata[14]}, 16'd1);
    clear_bw();
    peer_bw_chg = 1; tick();
    chk("R4 peer change", {15'd0, rdata[14]}, 16'd1);

    // R9: capture at entry only
    phy_width = 6'h08; in_l0 = 1; tick();
    chk("R9 capture x8", {10'd0, rdata[9:4]}, 16'h0008);
    phy_width = 6'h10; tick(); tick();
    chk("R9 hold in L0", {10'd0, rdata[9:4]}, 16'h0008);
    in_l0 = 0; tick();
    chk("R9 hold out of L0", {10'd0, rdata[9:4]}, 16'h0008);

    // R7
    dl_active = 1; tick();
    chk("R7 active", {15'd0, rdata[13]}, 16'd1);
    dl_active = 0; tick();

    // random mix
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(5) == 0) cfg_rec = ~cfg_rec;
      if ($urandom_range(6) == 0) in_l0 = ~in_l0;
      if ($urandom_range(3) == 0) begin
        case ($urandom_range(5))
          0: phy_width = 6'h01;
          1: phy_width = 6'h02;
          2: phy_width = 6'h04;
          3: phy_width = 6'h08;
          4: phy_width = 6'h10;
          default: phy_width = 6'($urandom);
        endcase
      end
      if ($urandom_range(4) == 0) dl_active = ~dl_active;
      retrain_cmd = ($urandom_range(11) == 0);
      auto_bw_chg = ($urandom_range(24) == 0);
      peer_bw_chg = ($urandom_range(24) == 0);
      dl_down     = ($urandom_range(29) == 0);
      reg_wr      = ($urandom_range(3) == 0);
      reg_wdata   = 16'($urandom);
      tick();
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule